// File: doc/BRIEF.md
# Shared Queue Occupancy and Age-Based Removal Controller

This block governs slot allocation in a queue that several hardware threads share. Each slot records whether it is in use, the thread that owns it and that thread's sequence number for the entry. From this slot state the block derives the number of entries each thread holds, the number of free slots, and full flags for the whole queue and for each thread. It also decides whether an incoming allocation request is granted and which slot it takes.

Each thread may hold only a limited number of entries, and that cap follows a sharing mode. In the dynamic mode any thread may take every slot. In the split mode the slots are divided evenly among the threads that are currently active. In the threshold mode every thread is held to a fixed parameter. Entries leave the queue by age. A commit frees the named thread's entries up to and including a sequence number. A squash frees the named thread's entries that are strictly younger than a sequence number. The surrounding pipeline uses the grant, the slot index and the valid vector to steer payload storage, which lies outside this block.

Top module: `occ_ctrl`

## Requirements
- R1: After synchronous active-low reset, no slot is valid, `free_count` equals ENTRIES, every thread count is zero and `drained` is high.
- R2: A granted allocation takes the lowest-numbered free slot, reports that index on `alloc_slot` in the same cycle, and the slot reads valid from the next cycle onward.
- R3: `thread_count[t]` equals the number of valid slots owned by thread t, and `free_count` equals ENTRIES minus the number of valid slots.
- R4: `queue_full` is high exactly when `free_count` is zero, and no allocation is granted while it is high.
- R5: With `share_mode` = 0 (dynamic), `thread_cap` equals ENTRIES.
- R6: With `share_mode` = 1 (split), `thread_cap` equals ENTRIES divided by the number of set bits in `active_mask`, rounded down, and is 0 when no thread is active.
- R7: With `share_mode` = 2 (threshold), `thread_cap` equals the THRESH parameter, clipped to ENTRIES. Code 3 behaves as dynamic.
- R8: `thread_full[t]` is high exactly when `thread_count[t]` is at least `thread_cap`, and a request from a thread whose flag is high is refused.
- R9: A commit for thread t with sequence value S frees every valid slot of t whose sequence number is less than or equal to S (unsigned compare). Other threads' slots are unchanged.
- R10: A squash for thread t with sequence value S frees every valid slot of t whose sequence number is strictly greater than S. Slots with sequence number S or older, and other threads' slots, are unchanged.
- R11: A request from a thread whose bit in `active_mask` is clear is refused.
- R12: When an allocation coincides with a commit or squash, the removal acts only on slots that were valid before the edge, so the new entry is kept even if its sequence number matches.
- R13: `drained` is high exactly when no slot is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| share_mode | input | 2 | Sharing mode: 0 dynamic, 1 split, 2 threshold, 3 dynamic |
| active_mask | input | THREADS | One bit per thread that is allowed to allocate |
| alloc_req | input | 1 | Allocation request |
| alloc_tid | input | TID_W | Requesting thread |
| alloc_seq | input | SEQ_W | Sequence number of the new entry |
| commit_valid | input | 1 | Commit strobe |
| commit_tid | input | TID_W | Thread being committed |
| commit_seq | input | SEQ_W | Youngest sequence number retired (inclusive) |
| squash_valid | input | 1 | Squash strobe |
| squash_tid | input | TID_W | Thread being squashed |
| squash_seq | input | SEQ_W | Youngest surviving sequence number |
| alloc_gnt | output | 1 | Request granted this cycle |
| alloc_slot | output | SLOT_W | Slot taken by the granted request |
| entry_valid | output | ENTRIES | Slot occupancy |
| thread_count | output | THREADS x CNT_W | Entries held by each thread |
| free_count | output | CNT_W | Unused slots |
| thread_cap | output | CNT_W | Current per-thread cap |
| queue_full | output | 1 | No free slot |
| thread_full | output | THREADS | Thread has reached its cap |
| drained | output | 1 | Queue empty |

## Verification
Directed sequences first fill one thread under the split mode past its cap, which separates the per-thread refusal from the global full condition. They then remove entries whose sequence numbers sit exactly on the commit and squash boundary, which separates an inclusive compare from an exclusive one. Allocations issued in the same cycle as removals show whether a new entry is wrongly caught by the removal. A dynamic-mode fill to capacity and a full drain exercise the global flags. A long constrained-random run then mixes modes, active masks, allocations and overlapping removals, and checks every output each cycle against a slot-level model in the bench.

// File: rtl/occ_pkg.sv
// Package: shared definitions for the queue occupancy controller.
package occ_pkg;
    typedef enum logic [1:0] {
        SHARE_DYNAMIC = 2'd0,
        SHARE_SPLIT   = 2'd1,
        SHARE_THRESH  = 2'd2,
        SHARE_SPARE   = 2'd3
    } share_mode_e;
endpackage

// File: rtl/occ_cap_calc.sv
// Module: occ_cap_calc
// Computes the per-thread entry cap from the sharing mode and active mask.
// Assumes THREADS >= 1; split quotients are constants chosen by active count.
module occ_cap_calc
    import occ_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int THREADS = 4,
    parameter int THRESH  = 6,
    localparam int CNT_W  = $clog2(ENTRIES + 1),
    localparam int ACT_W  = $clog2(THREADS + 1)
) (
    input  logic [1:0]         share_mode,
    input  logic [THREADS-1:0] active_mask,
    output logic [CNT_W-1:0]   cap
);
    localparam int THR_EFF = (THRESH > ENTRIES) ? ENTRIES : THRESH;

    logic [ACT_W-1:0]             act_cnt;
    logic [THREADS:0][CNT_W-1:0]  split_tab;
    share_mode_e                  mode;

    assign mode = share_mode_e'(share_mode);

    // Count active threads.
    always_comb begin
        act_cnt = '0;
        for (int t = 0; t < THREADS; t++)
            if (active_mask[t]) act_cnt = act_cnt + ACT_W'(1);
    end

    // Constant quotient for every possible active count.
    for (genvar k = 0; k <= THREADS; k++) begin : g_tab
        if (k == 0) begin : g_zero
            assign split_tab[k] = '0;
        end else begin : g_div
            assign split_tab[k] = CNT_W'(ENTRIES / k);
        end
    end

    // Select the cap for the current mode.
    always_comb begin
        unique case (mode)
            SHARE_SPLIT:  cap = split_tab[act_cnt];
            SHARE_THRESH: cap = CNT_W'(THR_EFF);
            default:      cap = CNT_W'(ENTRIES);
        endcase
    end

    // R7
    always_comb begin
        cap_range_chk: assert (cap <= CNT_W'(ENTRIES));
    end
endmodule

// File: rtl/occ_slot_store.sv
// Module: occ_slot_store
// Holds valid, owner thread and sequence number per slot; applies writes,
// commits (inclusive) and squashes (younger only); counts per-thread use.
// Assumes the writer only targets a free slot.
module occ_slot_store #(
    parameter int ENTRIES = 16,
    parameter int THREADS = 4,
    parameter int SEQ_W   = 16,
    localparam int CNT_W  = $clog2(ENTRIES + 1),
    localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [SLOT_W-1:0]             wr_slot,
    input  logic [TID_W-1:0]              wr_tid,
    input  logic [SEQ_W-1:0]              wr_seq,
    input  logic                          cm_v,
    input  logic [TID_W-1:0]              cm_tid,
    input  logic [SEQ_W-1:0]              cm_seq,
    input  logic                          sq_v,
    input  logic [TID_W-1:0]              sq_tid,
    input  logic [SEQ_W-1:0]              sq_seq,
    output logic [ENTRIES-1:0]            valid,
    output logic [THREADS-1:0][CNT_W-1:0] occ
);
    logic [ENTRIES-1:0]             v_q;
    logic [ENTRIES-1:0][TID_W-1:0]  tid_q;
    logic [ENTRIES-1:0][SEQ_W-1:0]  seq_q;
    logic [ENTRIES-1:0]             hit_cm;
    logic [ENTRIES-1:0]             hit_sq;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        assign hit_cm[i] = v_q[i] && cm_v && (tid_q[i] == cm_tid) && (seq_q[i] <= cm_seq);
        assign hit_sq[i] = v_q[i] && sq_v && (tid_q[i] == sq_tid) && (seq_q[i] >  sq_seq);

        // Slot update: write wins, else age-based removal.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q[i]   <= 1'b0;
                tid_q[i] <= '0;
                seq_q[i] <= '0;
            end else if (wr_en && (wr_slot == SLOT_W'(i))) begin
                v_q[i]   <= 1'b1;
                tid_q[i] <= wr_tid;
                seq_q[i] <= wr_seq;
            end else if (hit_cm[i] || hit_sq[i]) begin
                v_q[i]   <= 1'b0;
            end
        end

        // R10
        squash_keeps_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (v_q[i] && sq_v && (tid_q[i] == sq_tid) && (seq_q[i] <= sq_seq) && !hit_cm[i])
            |=> v_q[i]);
    end

    assign valid = v_q;

    // Per-thread occupancy counts.
    always_comb begin
        for (int t = 0; t < THREADS; t++) begin
            occ[t] = '0;
            for (int i = 0; i < ENTRIES; i++)
                if (v_q[i] && (tid_q[i] == TID_W'(t))) occ[t] = occ[t] + CNT_W'(1);
        end
    end

    // R2
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !v_q[wr_slot]);
endmodule

// File: rtl/occ_alloc_pick.sv
// Module: occ_alloc_pick
// Picks the lowest free slot and decides the grant for one request.
// Assumes thread_full is current for the present state.
module occ_alloc_pick #(
    parameter int ENTRIES = 16,
    parameter int THREADS = 4,
    localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic               req,
    input  logic [TID_W-1:0]   tid,
    input  logic [THREADS-1:0] active_mask,
    input  logic [THREADS-1:0] thread_full,
    output logic               gnt,
    output logic [SLOT_W-1:0]  slot
);
    logic any_free;

    // Lowest-index free slot search.
    always_comb begin
        slot     = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                slot     = SLOT_W'(i);
                any_free = 1'b1;
            end
        end
    end

    // Grant when the thread is active, under its cap and a slot is free.
    assign gnt = req && active_mask[tid] && !thread_full[tid] && any_free;
endmodule

// File: rtl/occ_ctrl.sv
// Module: occ_ctrl
// Top of the shared-queue occupancy controller: per-thread caps by sharing
// mode, allocation grant, sequence-number based commit and squash.
// Assumes sequence numbers within a thread do not wrap while resident.
module occ_ctrl
    import occ_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int THREADS = 4,
    parameter int SEQ_W   = 16,
    parameter int THRESH  = 6,
    localparam int CNT_W  = $clog2(ENTRIES + 1),
    localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    share_mode,
    input  logic [THREADS-1:0]            active_mask,
    input  logic                          alloc_req,
    input  logic [TID_W-1:0]              alloc_tid,
    input  logic [SEQ_W-1:0]              alloc_seq,
    input  logic                          commit_valid,
    input  logic [TID_W-1:0]              commit_tid,
    input  logic [SEQ_W-1:0]              commit_seq,
    input  logic                          squash_valid,
    input  logic [TID_W-1:0]              squash_tid,
    input  logic [SEQ_W-1:0]              squash_seq,
    output logic                          alloc_gnt,
    output logic [SLOT_W-1:0]             alloc_slot,
    output logic [ENTRIES-1:0]            entry_valid,
    output logic [THREADS-1:0][CNT_W-1:0] thread_count,
    output logic [CNT_W-1:0]              free_count,
    output logic [CNT_W-1:0]              thread_cap,
    output logic                          queue_full,
    output logic [THREADS-1:0]            thread_full,
    output logic                          drained
);
    logic [CNT_W:0] occ_sum;

    occ_cap_calc #(.ENTRIES(ENTRIES), .THREADS(THREADS), .THRESH(THRESH)) u_cap (
        .share_mode  (share_mode),
        .active_mask (active_mask),
        .cap         (thread_cap)
    );

    occ_slot_store #(.ENTRIES(ENTRIES), .THREADS(THREADS), .SEQ_W(SEQ_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (alloc_gnt),
        .wr_slot (alloc_slot),
        .wr_tid  (alloc_tid),
        .wr_seq  (alloc_seq),
        .cm_v    (commit_valid),
        .cm_tid  (commit_tid),
        .cm_seq  (commit_seq),
        .sq_v    (squash_valid),
        .sq_tid  (squash_tid),
        .sq_seq  (squash_seq),
        .valid   (entry_valid),
        .occ     (thread_count)
    );

    // Per-thread full flags against the common cap.
    for (genvar t = 0; t < THREADS; t++) begin : g_full
        assign thread_full[t] = (thread_count[t] >= thread_cap);
    end

    occ_alloc_pick #(.ENTRIES(ENTRIES), .THREADS(THREADS)) u_pick (
        .valid       (entry_valid),
        .req         (alloc_req),
        .tid         (alloc_tid),
        .active_mask (active_mask),
        .thread_full (thread_full),
        .gnt         (alloc_gnt),
        .slot        (alloc_slot)
    );

    // Global free count and status flags.
    assign free_count = CNT_W'(ENTRIES) - CNT_W'($countones(entry_valid));
    assign queue_full = (free_count == '0);
    assign drained    = (entry_valid == '0);

    // Sum of per-thread counts, used only by the occupancy check.
    always_comb begin
        occ_sum = '0;
        for (int t = 0; t < THREADS; t++) occ_sum = occ_sum + (CNT_W+1)'(thread_count[t]);
    end

    // R3
    occ_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_sum + (CNT_W+1)'(free_count)) == (CNT_W+1)'(ENTRIES));

    // R4
    full_blocks_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        queue_full |-> !alloc_gnt);

    // R8
    cap_blocks_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thread_full[alloc_tid] |-> !alloc_gnt);

    // R2
    gnt_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_gnt |=> entry_valid[$past(alloc_slot)]);

    // R13
    drained_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drained |-> (thread_count == '0));
endmodule

// File: tb/occ_ctrl_test.sv
`timescale 1ns/1ps
module occ_ctrl_test;
    localparam int E = 16;
    localparam int T = 4;
    localparam int SW = 16;
    localparam int TH = 6;
    localparam int CW = $clog2(E + 1);
    localparam int TW = 2;
    localparam int SLW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] share_mode = 2'd0;
    logic [T-1:0] active_mask = '1;
    logic alloc_req = 1'b0;
    logic [TW-1:0] alloc_tid = '0;
    logic [SW-1:0] alloc_seq = '0;
    logic commit_valid = 1'b0;
    logic [TW-1:0] commit_tid = '0;
    logic [SW-1:0] commit_seq = '0;
    logic squash_valid = 1'b0;
    logic [TW-1:0] squash_tid = '0;
    logic [SW-1:0] squash_seq = '0;
    logic alloc_gnt;
    logic [SLW-1:0] alloc_slot;
    logic [E-1:0] entry_valid;
    logic [T-1:0][CW-1:0] thread_count;
    logic [CW-1:0] free_count;
    logic [CW-1:0] thread_cap;
    logic queue_full;
    logic [T-1:0] thread_full;
    logic drained;

    occ_ctrl #(.ENTRIES(E), .THREADS(T), .SEQ_W(SW), .THRESH(TH)) uut (
        .clk(clk), .rst_n(rst_n), .share_mode(share_mode), .active_mask(active_mask),
        .alloc_req(alloc_req), .alloc_tid(alloc_tid), .alloc_seq(alloc_seq),
        .commit_valid(commit_valid), .commit_tid(commit_tid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_tid(squash_tid), .squash_seq(squash_seq),
        .alloc_gnt(alloc_gnt), .alloc_slot(alloc_slot), .entry_valid(entry_valid),
        .thread_count(thread_count), .free_count(free_count), .thread_cap(thread_cap),
        .queue_full(queue_full), .thread_full(thread_full), .drained(drained)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit mv[E];
    int mt[E];
    int ms[E];
    int gseq = 1;

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_cap();
        int n = 0;
        for (int t = 0; t < T; t++) if (active_mask[t]) n++;
        case (share_mode)
            2'd1: return (n == 0) ? 0 : E / n;
            2'd2: return (TH > E) ? E : TH;
            default: return E;
        endcase
    endfunction

    function automatic string cap_tag();
        case (share_mode)
            2'd1: return "R6";
            2'd2: return "R7";
            2'd3: return "R7";
            default: return "R5";
        endcase
    endfunction

    function automatic int mcount(int t);
        int n = 0;
        for (int i = 0; i < E; i++) if (mv[i] && mt[i] == t) n++;
        return n;
    endfunction

    function automatic int mused();
        int n = 0;
        for (int i = 0; i < E; i++) if (mv[i]) n++;
        return n;
    endfunction

    task automatic check_state(string vtag);
        logic [E-1:0] ev;
        int cap = exp_cap();
        for (int i = 0; i < E; i++) ev[i] = mv[i];
        chk(entry_valid == ev, vtag, int'(entry_valid), int'(ev));
        chk(int'(free_count) == E - mused(), "R3", int'(free_count), E - mused());
        for (int t = 0; t < T; t++) begin
            chk(int'(thread_count[t]) == mcount(t), "R3", int'(thread_count[t]), mcount(t));
            chk(thread_full[t] == (mcount(t) >= cap), "R8", int'(thread_full[t]), int'(mcount(t) >= cap));
        end
        chk(int'(thread_cap) == cap, cap_tag(), int'(thread_cap), cap);
        chk(queue_full == (mused() == E), "R4", int'(queue_full), int'(mused() == E));
        chk(drained == (mused() == 0), "R13", int'(drained), int'(mused() == 0));
    endtask

    // One cycle of stimulus with grant prediction and model update.
    task automatic step(string tag, bit rq, int tid, int seq, bit cv, int ct, int cs,
                        bit sv, int st, int ss);
        bit eg;
        int es = 0;
        alloc_req = rq; alloc_tid = TW'(tid); alloc_seq = SW'(seq);
        commit_valid = cv; commit_tid = TW'(ct); commit_seq = SW'(cs);
        squash_valid = sv; squash_tid = TW'(st); squash_seq = SW'(ss);
        #1;
        for (int i = E - 1; i >= 0; i--) if (!mv[i]) es = i;
        eg = rq && active_mask[tid] && (mcount(tid) < exp_cap()) && (mused() < E);
        chk(alloc_gnt == eg, tag, int'(alloc_gnt), int'(eg));
        if (eg) chk(int'(alloc_slot) == es, "R2", int'(alloc_slot), es);
        @(posedge clk);
        for (int i = 0; i < E; i++) begin
            if (mv[i] && cv && mt[i] == ct && ms[i] <= cs) mv[i] = 1'b0;
            if (mv[i] && sv && mt[i] == st && ms[i] > ss) mv[i] = 1'b0;
        end
        if (eg) begin mv[es] = 1'b1; mt[es] = tid; ms[es] = seq; end
        @(negedge clk);
        alloc_req = 1'b0; commit_valid = 1'b0; squash_valid = 1'b0;
        check_state(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'h0C0FFEE));
        for (int i = 0; i < E; i++) begin mv[i] = 1'b0; mt[i] = 0; ms[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_state("R1");
        chk(int'(free_count) == E, "R1", int'(free_count), E);
        chk(drained == 1'b1, "R1", int'(drained), 1);

        // R6 split among four threads: cap 4, fifth request refused (R8)
        share_mode = 2'd1; active_mask = 4'b1111;
        for (int k = 1; k <= 5; k++) step("R6", 1, 0, k, 0, 0, 0, 0, 0, 0);
        chk(int'(thread_count[0]) == 4, "R8", int'(thread_count[0]), 4);

        // R6 two active threads: cap 8; R11 inactive thread refused
        active_mask = 4'b0011;
        step("R11", 1, 2, 50, 0, 0, 0, 0, 0, 0);
        chk(int'(thread_count[2]) == 0, "R11", int'(thread_count[2]), 0);

        // R9 inclusive commit together with an allocation (R12)
        step("R9", 1, 1, 1, 1, 0, 2, 0, 0, 0);
        chk(int'(thread_count[0]) == 2, "R9", int'(thread_count[0]), 2);
        chk(int'(thread_count[1]) == 1, "R12", int'(thread_count[1]), 1);

        // R12 matching commit does not remove the entry written this cycle
        step("R12", 1, 1, 2, 1, 1, 2, 0, 0, 0);
        chk(int'(thread_count[1]) == 1, "R12", int'(thread_count[1]), 1);

        // R10 squash boundary: seq 3 stays, seq 4 goes
        step("R10", 0, 0, 0, 0, 0, 0, 1, 0, 3);
        chk(int'(thread_count[0]) == 1, "R10", int'(thread_count[0]), 1);
        step("R10", 1, 0, 9, 0, 0, 0, 1, 0, 0);
        chk(int'(thread_count[0]) == 1, "R12", int'(thread_count[0]), 1);

        // R7 threshold and spare code
        share_mode = 2'd2; @(negedge clk); check_state("R7");
        share_mode = 2'd3; @(negedge clk); check_state("R7");

        // R4 dynamic fill to capacity
        share_mode = 2'd0; active_mask = 4'b1111;
        for (int k = 0; k < 20; k++) step("R4", 1, k % T, 100 + k, 0, 0, 0, 0, 0, 0);
        chk(queue_full == 1'b1, "R4", int'(queue_full), 1);

        // R13 drain every thread
        for (int t = 0; t < T; t++) step("R13", 0, 0, 0, 1, t, 16'hFFFF, 0, 0, 0);
        chk(drained == 1'b1, "R13", int'(drained), 1);

        // R6 no active thread: cap 0
        share_mode = 2'd1; active_mask = 4'b0000;
        step("R6", 1, 0, 5, 0, 0, 0, 0, 0, 0);

        // Constrained random traffic
        gseq = 200;
        for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom_range(0, 99));
            bit rq = r < 70;
            bit cv = ($urandom_range(0, 9) < 2);
            bit sv = ($urandom_range(0, 19) < 1);
            if ($urandom_range(0, 49) == 0) share_mode = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 49) == 0) active_mask = 4'($urandom_range(1, 15));
            gseq++;
            step("R2", rq, int'($urandom_range(0, T - 1)), gseq,
                 cv, int'($urandom_range(0, T - 1)), gseq - int'($urandom_range(0, 30)),
                 sv, int'($urandom_range(0, T - 1)), gseq - int'($urandom_range(0, 30)));
        end
        finish_run();
    end
endmodule